// File: doc/BRIEF.md
# Inverted-Polarity Serial Byte Transmitter

This block sends one byte at a time over a single asynchronous serial line. Its polarity is reversed from the common convention. The line rests low. A frame opens with a high start bit, carries the eight data bits least significant first, and closes with a low stop bit. Each bit occupies a fixed number of clock cycles, 16 by default. At a 10 MHz clock this gives a rate of 625 kb/s.

A frame is requested by pulling the active-low request input down. Only the high-to-low transition of the request counts. The request first passes through two synchroniser flip-flops and then an edge detector, so it may come from an asynchronous source such as a button. When the stop bit has ended, the block raises a completion flag for exactly one bit time. It then re-arms and waits for the next falling edge of the request. Internally a bit-time divider, a loadable shift register and a bit counter are steered by a three-state controller.

Top module: `inv_frame_tx`

## Requirements
- R1: While reset is asserted, and after reset is released with no request yet made, `line_o` and `done_o` are both 0.
- R2: Whenever no frame is being sent and no completion flag is shown, `line_o` is held at 0.
- R3: If `send_n` is sampled low at rising edge n, having been sampled high at edge n-1 while the block is idle, the start bit (`line_o` = 1) appears right after edge n+2. It is still 0 after edge n+1.
- R4: A frame on `line_o` is a start bit of 1, then `byte_i` bit 0 up to bit 7 in that order, then a stop bit of 0. `byte_i` is sampled when the start bit is launched.
- R5: Every bit of the frame, start and stop included, lasts exactly BIT_CYCLES (16) clock cycles. The line changes only on these bit boundaries.
- R6: `done_o` rises on the clock edge at which the stop bit ends. It stays 1 for exactly BIT_CYCLES cycles and then returns to 0. `line_o` is 0 throughout.
- R7: Keeping `send_n` low does not start another frame. Only a new high-to-low transition does.
- R8: A falling edge of `send_n` that is detected while a frame or its completion flag is in progress is discarded. It neither disturbs the current frame nor starts a later one.
- R9: A falling edge that is detected on or after the cycle in which `done_o` returns to 0 starts a new frame with the usual timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_n | input | 1 | Active-low frame request; its falling edge launches a frame |
| byte_i | input | 8 | Data byte to send, sampled at frame launch |
| line_o | output | 1 | Serial output line (idle 0, start 1, stop 0) |
| done_o | output | 1 | Completion flag, high for one bit time after the stop bit |

## Verification
Two events can land in the same cycle: a freshly detected request edge, and a frame or completion flag that is still in progress. The bench provokes this in three ways. It releases the request and presses it again in the middle of a frame. It presses it again during the completion window. It also holds the request low for many cycles after the frame. In each case it expects the running frame to keep its exact bit pattern and a silent line afterwards. The opposite case is also provoked: a request placed immediately after the completion flag clears, which must start a correctly timed frame.

// File: rtl/inv_tx_pkg.sv
package inv_tx_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SEND = 2'd1,
        S_DONE = 2'd2
    } tx_state_e;
endpackage

// File: rtl/inv_tx_bittimer.sv
module inv_tx_bittimer #(
    parameter int BIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = $clog2(BIT_CYCLES > 1 ? BIT_CYCLES : 2);
    localparam logic [CW-1:0] MAX_C = CW'(BIT_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clr_i) begin
            tmr_d.cnt = '0;
        end else if (en_i) begin
            tmr_d.cnt = (tmr_q.cnt == MAX_C) ? '0 : tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tick_o = en_i && !clr_i && (tmr_q.cnt == MAX_C);

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= MAX_C);
endmodule

// File: rtl/inv_tx_shreg.sv
module inv_tx_shreg #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             bit_o
);
    typedef struct packed {
        logic [WIDTH-1:0] sh;
    } sr_t;

    sr_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i) begin
            sr_d.sh = par_i;
        end else if (shift_i) begin
            sr_d.sh = {1'b0, sr_q.sh[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign bit_o = sr_q.sh[0];

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> $stable(bit_o));
endmodule

// File: rtl/inv_tx_bitcnt.sv
module inv_tx_bitcnt #(
    parameter int LAST = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(LAST + 1 > 1 ? LAST + 1 : 2);
    localparam logic [CW-1:0] LAST_C = CW'(LAST);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } bc_t;

    bc_t bc_d, bc_q;

    always_comb begin
        bc_d = bc_q;
        if (clr_i)      bc_d.cnt = '0;
        else if (inc_i) bc_d.cnt = bc_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bc_q <= '0;
        else        bc_q <= bc_d;
    end

    assign last_o = (bc_q.cnt == LAST_C);

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc_q.cnt <= LAST_C);
endmodule

// File: rtl/inv_frame_tx.sv
module inv_frame_tx
    import inv_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_n,
    input  logic [DATA_W-1:0] byte_i,
    output logic              line_o,
    output logic              done_o
);
    localparam int   FRAME_BITS = DATA_W + 2;
    localparam logic START_LVL  = 1'b1;
    localparam logic STOP_LVL   = 1'b0;

    typedef struct packed {
        tx_state_e  st;
        logic [2:0] sync;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic fall, tick, last, load, shift, cnt_inc;
    logic [FRAME_BITS-1:0] frame_vec;

    assign fall      = ctl_q.sync[2] && !ctl_q.sync[1];
    assign frame_vec = {STOP_LVL, byte_i, START_LVL};

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.sync = {ctl_q.sync[1:0], send_n};
        load       = 1'b0;
        shift      = 1'b0;
        unique case (ctl_q.st)
            S_IDLE: begin
                if (fall) begin
                    load     = 1'b1;
                    ctl_d.st = S_SEND;
                end
            end
            S_SEND: begin
                if (tick) begin
                    shift = 1'b1;
                    if (last) ctl_d.st = S_DONE;
                end
            end
            S_DONE: begin
                if (tick) ctl_d.st = S_IDLE;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    assign cnt_inc = shift && !last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= S_IDLE;
            ctl_q.sync <= 3'b111;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    inv_tx_bittimer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (load),
        .en_i  (ctl_q.st != S_IDLE),
        .tick_o(tick)
    );

    inv_tx_shreg #(.WIDTH(FRAME_BITS)) u_shreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .shift_i(shift),
        .par_i  (frame_vec),
        .bit_o  (line_o)
    );

    inv_tx_bitcnt #(.LAST(FRAME_BITS - 1)) u_bitcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (load),
        .inc_i (cnt_inc),
        .last_o(last)
    );

    assign done_o = (ctl_q.st == S_DONE);

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_IDLE) |-> !line_o);

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !line_o);

    // R3
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_IDLE && fall) |=> line_o);

    // R8
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_SEND && !tick) |=> (ctl_q.st == S_SEND));
endmodule

// File: tb/inv_frame_tx_bench.sv
module inv_frame_tx_bench;
    localparam int BITC = 16;
    localparam int FIRST = 3;
    localparam int FRAME_END = FIRST + 10 * BITC;
    localparam int DONE_END = FRAME_END + BITC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       send_n = 1'b1;
    logic [7:0] byte_i = 8'h00;
    logic       line_o, done_o;

    int total = 0;
    int bad = 0;
    int seed_v;

    always #2 clk = ~clk;

    inv_frame_tx u_inv_frame_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .send_n(send_n),
        .byte_i(byte_i),
        .line_o(line_o),
        .done_o(done_o)
    );

    function automatic logic exp_bit(input logic [7:0] d, input int b);
        if (b == 0) return 1'b1;
        if (b == 9) return 1'b0;
        return d[b-1];
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            check(line_o, 1'b0, {tag, " line"});
            check(done_o, 1'b0, {tag, " done"});
        end
    endtask

    // low_len: release cycle (0 = keep low); rep_at: second press cycle (0 = none)
    task automatic send_frame(input logic [7:0] d, input int low_len, input int rep_at);
        @(negedge clk);
        byte_i = d;
        send_n = 1'b0;
        for (int k = 1; k <= DONE_END + 1; k++) begin
            @(posedge clk); #1;
            if (low_len != 0 && k == low_len) send_n = 1'b1;
            if (rep_at != 0 && k == rep_at) send_n = 1'b0;
            if (rep_at != 0 && k == rep_at + 5) send_n = 1'b1;
            if (k < FIRST) begin
                check(line_o, 1'b0, "R3 early");
            end else if (k < FRAME_END) begin
                if (((k - FIRST) % BITC) == 0)
                    check(line_o, exp_bit(d, (k - FIRST) / BITC), "R5 boundary");
                else
                    check(line_o, exp_bit(d, (k - FIRST) / BITC),
                          rep_at != 0 ? "R8 bit" : "R4 bit");
            end else begin
                check(line_o, 1'b0, "R6 line");
            end
            check(done_o, (k >= FRAME_END && k < DONE_END), "R6 done");
        end
    endtask

    initial begin
        seed_v = $urandom(32'h00C0FFEE);
        // R1
        repeat (3) @(posedge clk);
        #1;
        check(line_o, 1'b0, "R1 line in reset");
        check(done_o, 1'b0, "R1 done in reset");
        @(negedge clk);
        rst_n = 1'b1;
        idle_cycles(6, "R1");

        // directed: all zeros, all ones
        send_frame(8'h00, 4, 0);
        idle_cycles(5, "R2");
        send_frame(8'hFF, 10, 0);
        idle_cycles(5, "R2");

        // R7: request held low past the whole frame
        send_frame(8'hA5, 0, 0);
        idle_cycles(40, "R7");
        @(negedge clk);
        send_n = 1'b1;
        idle_cycles(5, "R7");

        // R8: re-press in middle of frame, and during completion window
        send_frame(8'h3C, 5, 70);
        idle_cycles(30, "R8");
        send_frame(8'h5A, 5, DONE_END - 14);
        idle_cycles(30, "R8");

        // R9: back-to-back frames with no idle gap
        send_frame(8'h81, 3, 0);
        send_frame(8'h7E, 3, 0);
        idle_cycles(3, "R9");

        // constrained random frames
        for (int n = 0; n < 20; n++) begin
            logic [7:0] d;
            int ll, ra;
            d  = 8'($urandom);
            ll = 3 + int'($urandom % 28);
            ra = (($urandom % 3) == 0) ? 40 + int'($urandom % 120) : 0;
            send_frame(d, ll, ra);
            idle_cycles(int'($urandom % 12), "R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule